// File: doc/BRIEF.md
# Prioritized Dual-Target Interrupt Controller

This block arbitrates a vector of maskable interrupt requests together with a fixed group of non-maskable exception sources, and presents one winning vector to a main CPU and another to a companion coprocessor. Each maskable line has a configuration entry with a 3-bit priority level and a routing bit. The routing bit sends the line to one of the two targets. Software fills these entries through a simple write port.

The CPU side supports nested interrupts. On each acknowledge, the current CPU level is saved on a small stack and the level rises to that of the taken request. On each return, the saved level comes back. The coprocessor side has a different rule: one base thread can run, and at most one nested thread on top of it. Six non-maskable sources and a request line gated by a separate mask bit are arbitrated ahead of every maskable CPU request. When a CPU request disappears before the CPU fetches its vector, the CPU gets a dedicated spurious vector.

Both targets see a registered result, one clock after the inputs that produced it. The result already takes into account any acknowledge or return given in the previous cycle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `cpu_req_o` and `cop_req_o` are low, `cpu_vec_o` is 7 (the spurious code), and every configuration entry holds level 0 with routing to the CPU.
- R2: A maskable line whose configured level is 0 never raises a request on either target. Levels 1 to 7 enable the line, and 7 is the most urgent.
- R3: Routing bit 0 sends line i to the CPU as vector 8+i. Routing bit 1 sends it to the coprocessor as `cop_vec_o` = i.
- R4: Among the eligible lines for one target, the highest level wins. On equal levels, the lowest index wins. The result appears on the outputs one clock after the request inputs are sampled.
- R5: A CPU-routed line is eligible only if its level is strictly greater than the current CPU level. An acknowledge while `cpu_req_o` is high raises the current level to the level of the taken vector. The non-maskable sources and the gated line count as level 7.
- R6: A CPU return restores the level saved at the matching acknowledge. The save stack holds up to STACK_D entries.
- R7: `i_mask_i` high blocks all CPU-routed maskable lines. It has no effect on coprocessor-routed lines.
- R8: `xirq_i` gives CPU vector 6 when `x_mask_i` is low. While `x_mask_i` is high, `xirq_i` is ignored.
- R9: Any asserted `nmi_i` bit wins over all other CPU sources, regardless of masks and current level. It gives vector equal to its bit index (0 to 5), and the lowest asserted bit wins.
- R10: When no CPU source is eligible, `cpu_req_o` is low and `cpu_vec_o` is 7. An acknowledge in that state leaves the CPU level unchanged.
- R11: With no coprocessor thread running, any enabled coprocessor line may be taken. With one thread running, only a strictly higher level may be taken. With two threads running, no coprocessor request is raised.
- R12: A coprocessor return drops one nesting level, and requests are then re-arbitrated against the remaining running level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_IRQ | Maskable request lines, level sensitive |
| nmi_i | input | 6 | Non-maskable sources; bit 0 has the highest priority |
| xirq_i | input | 1 | Request line gated by the X mask |
| i_mask_i | input | 1 | CPU mask for CPU-routed maskable lines, 1 = masked |
| x_mask_i | input | 1 | Mask for xirq_i, 1 = masked |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W | Index of the entry to write |
| cfg_lvl_i | input | 3 | Level to write, 0 = disabled |
| cfg_cop_i | input | 1 | Routing to write, 1 = coprocessor |
| cpu_ack_i | input | 1 | CPU vector fetch / acknowledge strobe |
| cpu_rti_i | input | 1 | CPU return-from-interrupt strobe |
| cop_ack_i | input | 1 | Coprocessor acknowledge strobe |
| cop_rti_i | input | 1 | Coprocessor thread-end strobe |
| cpu_req_o | output | 1 | CPU request flag |
| cpu_vec_o | output | VEC_W | CPU vector index |
| cop_req_o | output | 1 | Coprocessor request flag |
| cop_vec_o | output | IDX_W | Coprocessor vector index (line number) |

## Verification
Ordering is tried with several pattern types:
- Lines of equal level, which isolate the index tie-break from level comparison.
- Lines at a lower, equal and higher level than the one being serviced, which separate preemption from blocking.
- Returns, which show that the saved level is restored and not simply cleared.

On the coprocessor side, a third request at the top level is held off while two threads run, which distinguishes the two-deep cap from plain level ordering. A request withdrawn before the fetch, and non-maskable bits raised while both masks are set and the CPU sits at level 7, show that the fixed sources and the spurious vector are handled apart from the maskable path.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W    = 3;
  localparam int LVL_MAX  = 7;
  localparam int NMI_N    = 6;
  localparam int VEC_XIRQ = 6;
  localparam int VEC_SPUR = 7;
  localparam int VEC_BASE = 8;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_cfg.sv
module irq_cfg
  import irq_pkg::*;
#(
  parameter int N_IRQ = 16,
  parameter int IDX_W = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  lvl_t                  lvl_i,
  input  logic                  cop_i,
  output lvl_t [N_IRQ-1:0]      lvl_o,
  output logic [N_IRQ-1:0]      cop_o
);
  lvl_t [N_IRQ-1:0] lvl_q;
  logic [N_IRQ-1:0] cop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      cop_q <= '0;
    end else if (we_i && (int'(idx_i) < N_IRQ)) begin
      lvl_q[idx_i] <= lvl_i;
      cop_q[idx_i] <= cop_i;
    end
  end

  assign lvl_o = lvl_q;
  assign cop_o = cop_q;
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_pkg::*;
#(
  parameter int N_IRQ = 16,
  parameter int IDX_W = 4
) (
  input  logic [N_IRQ-1:0] elig_i,
  input  lvl_t [N_IRQ-1:0] lvl_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o,
  output lvl_t             lvl_o
);
  // ascending scan with strict compare keeps the lowest index on ties
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    lvl_o   = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (elig_i[i] && (lvl_i[i] > lvl_o)) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
        lvl_o   = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_cpu_stack.sv
module irq_cpu_stack
  import irq_pkg::*;
#(
  parameter int STACK_D = 8,
  localparam int SP_W  = $clog2(STACK_D + 1),
  localparam int PTR_W = (STACK_D > 1) ? $clog2(STACK_D) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic            pop_i,
  input  lvl_t            push_lvl_i,
  output lvl_t            lvl_n_o,
  output lvl_t            lvl_q_o,
  output logic [SP_W-1:0] sp_o
);
  lvl_t            stack_q [STACK_D];
  lvl_t            lvl_q, lvl_n;
  logic [SP_W-1:0] sp_q, sp_n;
  logic            wr_en;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  assign wr_ptr = PTR_W'(sp_q);
  assign rd_ptr = PTR_W'(sp_q - 1'b1);

  always_comb begin
    lvl_n = lvl_q;
    sp_n  = sp_q;
    wr_en = 1'b0;
    if (push_i) begin
      lvl_n = push_lvl_i;
      if (int'(sp_q) < STACK_D) begin
        wr_en = 1'b1;
        sp_n  = sp_q + 1'b1;
      end
    end else if (pop_i && (sp_q != '0)) begin
      lvl_n = stack_q[rd_ptr];
      sp_n  = sp_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      sp_q  <= '0;
      for (int i = 0; i < STACK_D; i++) stack_q[i] <= '0;
    end else begin
      lvl_q <= lvl_n;
      sp_q  <= sp_n;
      if (wr_en) stack_q[wr_ptr] <= lvl_q;
    end
  end

  assign lvl_n_o = lvl_n;
  assign lvl_q_o = lvl_q;
  assign sp_o    = sp_q;
endmodule

// File: rtl/irq_cop_nest.sv
module irq_cop_nest
  import irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  logic       pop_i,
  input  lvl_t       push_lvl_i,
  output logic [1:0] depth_n_o,
  output logic [1:0] depth_q_o,
  output lvl_t       run_lvl_n_o
);
  logic [1:0] depth_q, depth_n;
  lvl_t       lvl_q [2];
  lvl_t       lvl_n [2];

  always_comb begin
    depth_n  = depth_q;
    lvl_n[0] = lvl_q[0];
    lvl_n[1] = lvl_q[1];
    if (push_i && (depth_q < 2'd2)) begin
      lvl_n[depth_q[0]] = push_lvl_i;
      depth_n           = depth_q + 2'd1;
    end else if (pop_i && (depth_q != 2'd0)) begin
      depth_n = depth_q - 2'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q  <= '0;
      lvl_q[0] <= '0;
      lvl_q[1] <= '0;
    end else begin
      depth_q  <= depth_n;
      lvl_q[0] <= lvl_n[0];
      lvl_q[1] <= lvl_n[1];
    end
  end

  assign depth_n_o   = depth_n;
  assign depth_q_o   = depth_q;
  assign run_lvl_n_o = (depth_n == 2'd0) ? lvl_t'(0)
                     : (depth_n == 2'd1) ? lvl_n[0] : lvl_n[1];
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int N_IRQ   = 16,
  parameter int STACK_D = 8,
  localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1,
  localparam int VEC_W = $clog2(N_IRQ + VEC_BASE),
  localparam int SP_W  = $clog2(STACK_D + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IRQ-1:0]  irq_i,
  input  logic [NMI_N-1:0]  nmi_i,
  input  logic              xirq_i,
  input  logic              i_mask_i,
  input  logic              x_mask_i,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [LVL_W-1:0]  cfg_lvl_i,
  input  logic              cfg_cop_i,
  input  logic              cpu_ack_i,
  input  logic              cpu_rti_i,
  input  logic              cop_ack_i,
  input  logic              cop_rti_i,
  output logic              cpu_req_o,
  output logic [VEC_W-1:0]  cpu_vec_o,
  output logic              cop_req_o,
  output logic [IDX_W-1:0]  cop_vec_o
);
  lvl_t [N_IRQ-1:0] cfg_lvl;
  logic [N_IRQ-1:0] cfg_cop;

  irq_cfg #(.N_IRQ(N_IRQ), .IDX_W(IDX_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i (cfg_we_i), .idx_i(cfg_idx_i), .lvl_i(cfg_lvl_i), .cop_i(cfg_cop_i),
    .lvl_o(cfg_lvl), .cop_o(cfg_cop)
  );

  // registered results
  logic             cpu_req_q, cop_req_q;
  logic [VEC_W-1:0] cpu_vec_q;
  logic [IDX_W-1:0] cop_vec_q;
  lvl_t             cpu_wlvl_q, cop_wlvl_q;

  // nesting state; arbitration uses next-state values so an ack/return
  // is reflected in the very next registered result
  lvl_t            cpu_lvl_n, cpu_lvl_q;
  logic [SP_W-1:0] cpu_sp;
  logic [1:0]      cop_depth_n, cop_depth_q;
  lvl_t            cop_run_n;

  irq_cpu_stack #(.STACK_D(STACK_D)) u_cpu_stack (
    .clk_i, .rst_ni,
    .push_i    (cpu_ack_i & cpu_req_q),
    .pop_i     (cpu_rti_i),
    .push_lvl_i(cpu_wlvl_q),
    .lvl_n_o   (cpu_lvl_n),
    .lvl_q_o   (cpu_lvl_q),
    .sp_o      (cpu_sp)
  );

  irq_cop_nest u_cop_nest (
    .clk_i, .rst_ni,
    .push_i     (cop_ack_i & cop_req_q),
    .pop_i      (cop_rti_i),
    .push_lvl_i (cop_wlvl_q),
    .depth_n_o  (cop_depth_n),
    .depth_q_o  (cop_depth_q),
    .run_lvl_n_o(cop_run_n)
  );

  logic [N_IRQ-1:0] cpu_elig, cop_elig;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_elig
    logic enabled;
    assign enabled     = irq_i[i] && (cfg_lvl[i] != '0);
    assign cpu_elig[i] = enabled && !cfg_cop[i] && !i_mask_i && (cfg_lvl[i] > cpu_lvl_n);
    assign cop_elig[i] = enabled &&  cfg_cop[i] && (cop_depth_n < 2'd2) && (cfg_lvl[i] > cop_run_n);
  end

  logic             cpu_found, cop_found;
  logic [IDX_W-1:0] cpu_idx, cop_idx;
  lvl_t             cpu_alvl, cop_alvl;

  irq_arb #(.N_IRQ(N_IRQ), .IDX_W(IDX_W)) u_cpu_arb (
    .elig_i(cpu_elig), .lvl_i(cfg_lvl),
    .found_o(cpu_found), .idx_o(cpu_idx), .lvl_o(cpu_alvl)
  );

  irq_arb #(.N_IRQ(N_IRQ), .IDX_W(IDX_W)) u_cop_arb (
    .elig_i(cop_elig), .lvl_i(cfg_lvl),
    .found_o(cop_found), .idx_o(cop_idx), .lvl_o(cop_alvl)
  );

  // fixed sources: lowest bit first
  logic                     nmi_hit;
  logic [$clog2(NMI_N)-1:0] nmi_idx;

  always_comb begin
    nmi_hit = |nmi_i;
    nmi_idx = '0;
    for (int i = NMI_N - 1; i >= 0; i--) begin
      if (nmi_i[i]) nmi_idx = ($clog2(NMI_N))'(i);
    end
  end

  logic             cpu_req_d;
  logic [VEC_W-1:0] cpu_vec_d;
  lvl_t             cpu_wlvl_d;

  always_comb begin
    cpu_req_d  = 1'b1;
    cpu_vec_d  = VEC_W'(VEC_SPUR);
    cpu_wlvl_d = lvl_t'(LVL_MAX);
    if (nmi_hit) begin
      cpu_vec_d = VEC_W'(nmi_idx);
    end else if (xirq_i && !x_mask_i) begin
      cpu_vec_d = VEC_W'(VEC_XIRQ);
    end else if (cpu_found) begin
      cpu_vec_d  = VEC_W'(VEC_BASE) + VEC_W'(cpu_idx);
      cpu_wlvl_d = cpu_alvl;
    end else begin
      cpu_req_d  = 1'b0;
      cpu_wlvl_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_req_q  <= 1'b0;
      cpu_vec_q  <= VEC_W'(VEC_SPUR);
      cpu_wlvl_q <= '0;
      cop_req_q  <= 1'b0;
      cop_vec_q  <= '0;
      cop_wlvl_q <= '0;
    end else begin
      cpu_req_q  <= cpu_req_d;
      cpu_vec_q  <= cpu_vec_d;
      cpu_wlvl_q <= cpu_wlvl_d;
      cop_req_q  <= cop_found;
      cop_vec_q  <= cop_found ? cop_idx : '0;
      cop_wlvl_q <= cop_found ? cop_alvl : '0;
    end
  end

  assign cpu_req_o = cpu_req_q;
  assign cpu_vec_o = cpu_vec_q;
  assign cop_req_o = cop_req_q;
  assign cop_vec_o = cop_vec_q;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import irq_pkg::*;
#(
  parameter int STACK_D = 8,
  parameter int VEC_W   = 5,
  parameter int SP_W    = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NMI_N-1:0] nmi_i,
  input logic             i_mask_i,
  input logic             cpu_ack_i,
  input logic             cpu_rti_i,
  input logic             cpu_req_o,
  input logic [VEC_W-1:0] cpu_vec_o,
  input logic             cop_req_o,
  input lvl_t             cpu_wlvl_q,
  input lvl_t             cpu_lvl_q,
  input logic [SP_W-1:0]  cpu_sp,
  input logic [1:0]       cop_depth_q
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_nmi_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(|nmi_i)) |-> (cpu_req_o && (int'(cpu_vec_o) < NMI_N)));

  p_imask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && cpu_req_o && (int'(cpu_vec_o) >= VEC_BASE)) |-> !$past(i_mask_i));

  p_strict_lvl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_o && (int'(cpu_vec_o) >= VEC_BASE)) |-> (cpu_wlvl_q > cpu_lvl_q));

  p_cop_cap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cop_depth_q == 2'd2) |-> !cop_req_o);

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cpu_sp) <= STACK_D);

  p_pop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(cpu_rti_i) && !$past(cpu_ack_i) && ($past(cpu_sp) != '0))
      |-> (int'(cpu_sp) == int'($past(cpu_sp)) - 1));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
  .STACK_D(STACK_D), .VEC_W(VEC_W), .SP_W(SP_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .nmi_i      (nmi_i),
  .i_mask_i   (i_mask_i),
  .cpu_ack_i  (cpu_ack_i),
  .cpu_rti_i  (cpu_rti_i),
  .cpu_req_o  (cpu_req_o),
  .cpu_vec_o  (cpu_vec_o),
  .cop_req_o  (cop_req_o),
  .cpu_wlvl_q (cpu_wlvl_q),
  .cpu_lvl_q  (cpu_lvl_q),
  .cpu_sp     (cpu_sp),
  .cop_depth_q(cop_depth_q)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  localparam int N_IRQ = 16;
  localparam int IDX_W = 4;
  localparam int VEC_W = 5;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [N_IRQ-1:0] irq_i = '0;
  logic [5:0]       nmi_i = '0;
  logic             xirq_i = 1'b0, i_mask_i = 1'b0, x_mask_i = 1'b0;
  logic             cfg_we_i = 1'b0, cfg_cop_i = 1'b0;
  logic [IDX_W-1:0] cfg_idx_i = '0;
  logic [2:0]       cfg_lvl_i = '0;
  logic             cpu_ack_i = 1'b0, cpu_rti_i = 1'b0, cop_ack_i = 1'b0, cop_rti_i = 1'b0;
  logic             cpu_req_o, cop_req_o;
  logic [VEC_W-1:0] cpu_vec_o;
  logic [IDX_W-1:0] cop_vec_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  prio_irq_ctrl #(.N_IRQ(N_IRQ), .STACK_D(8)) u_prio_irq_ctrl (
    .clk_i, .rst_ni, .irq_i, .nmi_i, .xirq_i, .i_mask_i, .x_mask_i,
    .cfg_we_i, .cfg_idx_i, .cfg_lvl_i, .cfg_cop_i,
    .cpu_ack_i, .cpu_rti_i, .cop_ack_i, .cop_rti_i,
    .cpu_req_o, .cpu_vec_o, .cop_req_o, .cop_vec_o
  );

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input int idx, input int lvl, input bit cop);
    cfg_we_i = 1'b1; cfg_idx_i = IDX_W'(idx); cfg_lvl_i = 3'(lvl); cfg_cop_i = cop;
    tick();
    cfg_we_i = 1'b0;
    tick();
  endtask

  task automatic cpu_ack();  cpu_ack_i = 1'b1; tick(); cpu_ack_i = 1'b0; endtask
  task automatic cpu_rti();  cpu_rti_i = 1'b1; tick(); cpu_rti_i = 1'b0; endtask
  task automatic cop_ack();  cop_ack_i = 1'b1; tick(); cop_ack_i = 1'b0; endtask
  task automatic cop_rti();  cop_rti_i = 1'b1; tick(); cop_rti_i = 1'b0; endtask

  task automatic t_reset();
    chk("R1 cpu_req", int'(cpu_req_o), 0);
    chk("R1 cop_req", int'(cop_req_o), 0);
    chk("R1 cpu_vec", int'(cpu_vec_o), 7);
    irq_i[15] = 1'b1;   // unconfigured, level 0
    tick();
    chk("R2 level0 cpu", int'(cpu_req_o), 0);
    chk("R2 level0 cop", int'(cop_req_o), 0);
    irq_i = '0; tick();
  endtask

  task automatic t_tie();
    cfg(1, 2, 0); cfg(2, 4, 0); cfg(5, 4, 0);
    irq_i[1] = 1'b1; irq_i[2] = 1'b1; irq_i[5] = 1'b1;
    tick();
    chk("R4 tie lowest idx", int'(cpu_vec_o), 10);
    chk("R3 cpu routed req", int'(cpu_req_o), 1);
    cfg(2, 0, 0);
    chk("R2 disabled line skipped", int'(cpu_vec_o), 13);
    irq_i = '0; tick();
  endtask

  task automatic t_nest();
    cfg(3, 3, 0); cfg(4, 5, 0); cfg(6, 3, 0); cfg(7, 4, 0);
    irq_i[3] = 1'b1; tick();
    chk("R4 single", int'(cpu_vec_o), 11);
    cpu_ack();
    chk("R5 own level blocked", int'(cpu_req_o), 0);
    irq_i[6] = 1'b1; tick();
    chk("R5 equal level blocked", int'(cpu_req_o), 0);
    irq_i[4] = 1'b1; tick();
    chk("R5 higher preempts", int'(cpu_vec_o), 12);
    cpu_ack();
    irq_i[4] = 1'b0; irq_i[7] = 1'b1; tick();
    chk("R5 lower blocked at 5", int'(cpu_req_o), 0);
    cpu_rti();
    chk("R6 restored level 3 req", int'(cpu_req_o), 1);
    chk("R6 restored level 3 vec", int'(cpu_vec_o), 15);
    cpu_rti();
    chk("R6 back to base vec", int'(cpu_vec_o), 15);
    irq_i = '0; tick();
  endtask

  task automatic t_mask();
    cfg(0, 2, 0); cfg(9, 2, 1);
    i_mask_i = 1'b1;
    irq_i[0] = 1'b1; irq_i[9] = 1'b1; tick();
    chk("R7 cpu masked", int'(cpu_req_o), 0);
    chk("R7 cop unaffected", int'(cop_req_o), 1);
    chk("R3 cop vector", int'(cop_vec_o), 9);
    i_mask_i = 1'b0; tick();
    chk("R7 unmasked", int'(cpu_vec_o), 8);
    irq_i = '0; tick();
  endtask

  task automatic t_cop();
    cfg(10, 2, 1); cfg(11, 5, 1); cfg(12, 2, 1); cfg(13, 7, 1);
    irq_i[10] = 1'b1; tick();
    chk("R11 base taken", int'(cop_vec_o), 10);
    cop_ack();
    irq_i[12] = 1'b1; tick();
    chk("R11 equal refused", int'(cop_req_o), 0);
    irq_i[11] = 1'b1; tick();
    chk("R11 nested higher", int'(cop_vec_o), 11);
    cop_ack();
    irq_i[13] = 1'b1; tick();
    chk("R11 second nesting refused", int'(cop_req_o), 0);
    cop_rti();
    chk("R12 after one return", int'(cop_vec_o), 13);
    chk("R12 after one return req", int'(cop_req_o), 1);
    cop_rti();
    chk("R12 idle", int'(cop_vec_o), 13);
    irq_i = '0; tick();
    chk("R11 none pending", int'(cop_req_o), 0);
  endtask

  task automatic t_spur();
    cfg(14, 6, 0);
    irq_i[14] = 1'b1; tick();
    chk("R4 level6", int'(cpu_vec_o), 22);
    irq_i[14] = 1'b0; tick();
    chk("R10 req dropped", int'(cpu_req_o), 0);
    chk("R10 spurious vec", int'(cpu_vec_o), 7);
    cpu_ack();
    chk("R10 spurious after ack", int'(cpu_vec_o), 7);
    irq_i[14] = 1'b1; tick();
    chk("R10 level unchanged", int'(cpu_vec_o), 22);
    irq_i = '0; tick();
  endtask

  task automatic t_nmi();
    i_mask_i = 1'b1; x_mask_i = 1'b1;
    irq_i[14] = 1'b1; nmi_i = 6'b001010; tick();
    chk("R9 lowest nmi bit", int'(cpu_vec_o), 1);
    cpu_ack_i = 1'b1; nmi_i[1] = 1'b0; tick(); cpu_ack_i = 1'b0;
    chk("R9 over level 7", int'(cpu_vec_o), 3);
    nmi_i = '0; tick();
    chk("R9 cleared", int'(cpu_req_o), 0);
    xirq_i = 1'b1; tick();
    chk("R8 x masked", int'(cpu_req_o), 0);
    x_mask_i = 1'b0; tick();
    chk("R8 x unmasked", int'(cpu_vec_o), 6);
    xirq_i = 1'b0; cpu_rti();
    i_mask_i = 1'b0; tick();
    chk("R7 maskable resumes", int'(cpu_vec_o), 22);
    irq_i = '0; tick();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    tick(); tick();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_tie();
    t_nest();
    t_mask();
    t_cop();
    t_spur();
    t_nmi();
    done = 1'b1;
    summary();
  end
endmodule